// File: doc/BRIEF.md
# Miss-Throttled Preloaded Instruction Cache

This block is a small instruction cache controller placed between a processor fetch port and a 256-byte main memory. After reset it copies the first part of the program from memory into a direct-mapped array of one-byte lines. Fetches are served only after this copy has finished and the processor has raised its start input.

In the active mode, fetches that hit the array are answered in the same cycle. A miss is fetched from memory and passed on to the processor, but it is not kept in the array. Two saturating counters tally hits and misses. A comparator watches them, and once misses strictly outnumber hits the controller raises a throttle flag and moves to the shadow mode. In the shadow mode each miss is still read from memory and returned to the processor, and it is also written into its line, so that later fetches of the same address hit.

A done input from the processor ends execution from either serving mode. The end mode then holds until reset.

Top module: `icache_throttled`

## Requirements
- R1: While reset is held low, mode reads 0 (preload) and throttle, fetchReady and memReq are all low.
- R2: In preload (mode 0) the controller reads memory addresses 0 up to PRELOAD_LEN-1 in ascending order, one request at a time, and fetchReady stays low. It enters active (mode 1) only when all of these lines are loaded and start is high.
- R3: In active or shadow mode, a fetch whose address is held in the array gets fetchReady high in the same cycle, with the stored byte on fetchData, and no memory request is made.
- R4: In active mode, a missing fetch issues one memory request for fetchAddr and completes in the cycle memValid is high, with fetchData equal to memData. The line is not filled, so the same address misses again.
- R5: Every completed fetch in active or shadow mode adds one to the hit or the miss counter. If after an access in active mode the miss count is strictly greater than the hit count, mode becomes 2 (shadow) and throttle rises one cycle after that access completes. Equal counts leave the controller in active mode.
- R6: In shadow mode, a missing fetch is served from memory and written into its line, replacing any line with the same index. Later fetches of that address hit.
- R7: Both counters saturate at 2^CNT_W-1 and do not wrap.
- R8: Throttle stays high for the whole time in shadow mode, however the counters change afterwards. A done pulse with no memory access pending moves the controller to mode 3 (end), with throttle low. In end mode fetches are never answered and no memory request is made, until reset.
- R9: memReq stays high from the start of a request until the cycle memValid is high, and a missing fetch is held stalled (fetchReady low) for at least the memory latency.
- R10: A done pulse in active mode also moves the controller to end mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Processor begins execution |
| done | input | 1 | Processor finished execution |
| fetchValid | input | 1 | Fetch request, held until fetchReady |
| fetchAddr | input | ADDR_W | Fetch address |
| fetchReady | output | 1 | Fetch answered this cycle |
| fetchData | output | DATA_W | Instruction byte |
| throttle | output | 1 | High in shadow mode |
| mode | output | 2 | 0 preload, 1 active, 2 shadow, 3 end |
| memReq | output | 1 | Memory read request, held until memValid |
| memAddr | output | ADDR_W | Memory read address |
| memValid | input | 1 | One-cycle read response strobe |
| memData | input | DATA_W | Read data from memory |

## Verification
The assertions assume that memory answers a request with one memValid pulse and never pulses memValid when no request is open. They also assume that the processor holds fetchValid and fetchAddr steady until fetchReady, and raises done only when no miss is waiting. The bench models memory with a fixed latency and one request at a time, drives each fetch and holds it until the ready cycle, and pulses done only between fetches. In this way the stimulus never leaves these limits.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    MODE_PRELOAD = 2'd0,
    MODE_ACTIVE  = 2'd1,
    MODE_SHADOW  = 2'd2,
    MODE_END     = 2'd3
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fill;
    logic incHit;
    logic incMiss;
  } dpStrobe_t;
endpackage

// File: rtl/icache_dp.sv
module icache_dp
  import icache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  input  logic [ADDR_W-1:0] lookAddr,
  output logic              hit,
  output logic [DATA_W-1:0] rdData,
  output logic              missOver
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [LINES-1:0]  lineValid;
  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [DATA_W-1:0] dataMem [LINES];
  logic [CNT_W-1:0]  hitCnt, missCnt;

  logic [IDX_W-1:0] lookIdx, fillIdx;
  logic [TAG_W-1:0] lookTag, fillTag;

  assign lookIdx = lookAddr[IDX_W-1:0];
  assign lookTag = lookAddr[ADDR_W-1:IDX_W];
  assign fillIdx = fillAddr[IDX_W-1:0];
  assign fillTag = fillAddr[ADDR_W-1:IDX_W];

  assign hit      = lineValid[lookIdx] && (tagMem[lookIdx] == lookTag);
  assign rdData   = dataMem[lookIdx];
  assign missOver = missCnt > hitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) lineValid <= '0;
    else if (strobe.fill) lineValid[fillIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      tagMem[fillIdx]  <= fillTag;
      dataMem[fillIdx] <= fillData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCnt  <= '0;
      missCnt <= '0;
    end else begin
      if (strobe.incHit && hitCnt != CNT_MAX)   hitCnt  <= hitCnt + 1'b1;
      if (strobe.incMiss && missCnt != CNT_MAX) missCnt <= missCnt + 1'b1;
    end
  end

  AST_HIT_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incHit && hitCnt == CNT_MAX) |=> hitCnt == CNT_MAX); // R7
  AST_MISS_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incMiss && missCnt == CNT_MAX) |=> missCnt == CNT_MAX); // R7
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> lineValid[$past(fillIdx)]); // R6
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PRELOAD_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              done,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              hit,
  input  logic              missOver,
  input  logic              memValid,
  output mode_e             mode,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              fetchReady,
  output dpStrobe_t         strobe
);
  localparam int PCNT_W = $clog2(PRELOAD_LEN + 1);
  localparam logic [PCNT_W-1:0] PRE_LAST = PCNT_W'(PRELOAD_LEN);

  logic [PCNT_W-1:0] preCnt;
  logic pending, run, memDone, serveHit, startMiss, startPre, preDone;

  assign run = (mode == MODE_ACTIVE && !missOver && !done) ||
               (mode == MODE_SHADOW && !done);
  assign memDone   = pending && memValid;
  assign serveHit  = run && !pending && fetchValid && hit;
  assign startMiss = run && !pending && fetchValid && !hit;
  assign preDone   = (preCnt == PRE_LAST);
  assign startPre  = (mode == MODE_PRELOAD) && !pending && !preDone;

  assign memReq     = pending;
  assign memAddr    = (mode == MODE_PRELOAD) ? ADDR_W'(preCnt) : fetchAddr;
  assign fetchReady = serveHit || (memDone && mode != MODE_PRELOAD);

  always_comb begin
    strobe         = '0;
    strobe.incHit  = serveHit;
    strobe.incMiss = memDone && mode != MODE_PRELOAD;
    strobe.fill    = memDone && (mode == MODE_PRELOAD || mode == MODE_SHADOW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      preCnt  <= '0;
      mode    <= MODE_PRELOAD;
    end else begin
      if (memDone) pending <= 1'b0;
      else if (startMiss || startPre) pending <= 1'b1;
      if (memDone && mode == MODE_PRELOAD) preCnt <= preCnt + 1'b1;
      case (mode)
        MODE_PRELOAD: if (preDone && !pending && start) mode <= MODE_ACTIVE;
        MODE_ACTIVE:  if (!pending) begin
                        if (done) mode <= MODE_END;
                        else if (missOver) mode <= MODE_SHADOW;
                      end
        MODE_SHADOW:  if (!pending && done) mode <= MODE_END;
        default:      mode <= MODE_END;
      endcase
    end
  end

  AST_NO_READY_PRELOAD: assert property (@(posedge clk) disable iff (!rstN)
    mode == MODE_PRELOAD |-> !fetchReady); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> memReq); // R9
  AST_SHADOW_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_ACTIVE && missOver && !done && !memReq) |=> mode == MODE_SHADOW); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SHADOW && !done) |=> mode == MODE_SHADOW); // R8
  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    mode == MODE_END |=> (mode == MODE_END && !fetchReady)); // R8
endmodule

// File: rtl/icache_throttled.sv
module icache_throttled
  import icache_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 4,
  parameter int CNT_W       = 8,
  parameter int PRELOAD_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              done,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic [DATA_W-1:0] fetchData,
  output logic              throttle,
  output logic [1:0]        mode,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData
);
  mode_e             modeQ;
  dpStrobe_t         strobe;
  logic              hit, missOver;
  logic [DATA_W-1:0] rdData;

  icache_ctrl #(.ADDR_W(ADDR_W), .PRELOAD_LEN(PRELOAD_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .done(done),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .hit(hit), .missOver(missOver), .memValid(memValid),
    .mode(modeQ), .memReq(memReq), .memAddr(memAddr),
    .fetchReady(fetchReady), .strobe(strobe)
  );

  icache_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fillAddr(memAddr), .fillData(memData), .lookAddr(fetchAddr),
    .hit(hit), .rdData(rdData), .missOver(missOver)
  );

  assign fetchData = memReq ? memData : rdData;
  assign throttle  = (modeQ == MODE_SHADOW);
  assign mode      = modeQ;

  AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReady && memValid) |-> fetchData == memData); // R4
endmodule

// File: tb/tb_icache_throttled.sv
module tb_icache_throttled;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;
  localparam int LEN = 16;

  logic clk = 1'b0, rstN, start, done, fetchValid, fetchReady, throttle;
  logic memReq, memValid;
  logic [7:0] fetchAddr, fetchData, memAddr, memData;
  logic [1:0] mode;

  int tests = 0, fails = 0, reqCount = 0;
  logic recordPre;
  logic [7:0] preLog[$];
  logic [7:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_throttled #(.CNT_W(3), .PRELOAD_LEN(LEN)) dut (
    .clk(clk), .rstN(rstN), .start(start), .done(done),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .fetchData(fetchData),
    .throttle(throttle), .mode(mode),
    .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData)
  );

  function automatic logic [7:0] memWord(input logic [7:0] a);
    return a * 8'd13 + 8'd7;
  endfunction

  // fixed-latency memory model
  logic busy;
  int latCnt;
  logic [7:0] reqAddr;
  always @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; memValid <= 1'b0; memData <= '0; latCnt <= 0;
    end else if (busy) begin
      if (latCnt == 0) begin
        memValid <= 1'b1; memData <= memWord(reqAddr); busy <= 1'b0;
      end else latCnt <= latCnt - 1;
    end else begin
      memValid <= 1'b0;
      if (memReq && !memValid) begin
        busy <= 1'b1; latCnt <= LAT - 1; reqAddr <= memAddr;
        reqCount <= reqCount + 1;
        if (recordPre) preLog.push_back(memAddr);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected data when a fetch is answered
  always @(negedge clk) begin
    #2;
    if (rstN && fetchValid && fetchReady) begin
      if (expQ.size() == 0) check("R3/R4 unexpected answer", 1, 0);
      else begin
        string t = tagQ.pop_front();
        check(t, fetchData, expQ.pop_front());
      end
    end
  end

  // driver: one fetch, held until answered
  task automatic fetch(input logic [7:0] a, input bit expHit, input string req);
    int r0, cycles;
    expQ.push_back(memWord(a)); tagQ.push_back(req);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = a; r0 = reqCount; cycles = 0;
    #1;
    while (!fetchReady) begin @(negedge clk); #1; cycles++; end
    @(posedge clk); #1;
    fetchValid = 1'b0;
    check(req, reqCount - r0, expHit ? 0 : 1);
    if (expHit) check(req, cycles, 0);
    else check("R9 stall length", int'(cycles >= LAT), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ordered, sawReady;
    int r0, guard;
    rstN = 0; start = 0; done = 0; fetchValid = 0; fetchAddr = '0; recordPre = 1;
    repeat (3) @(negedge clk);
    check("R1 mode", mode, 0);
    check("R1 throttle", throttle, 0);
    check("R1 fetchReady", fetchReady, 0);
    check("R1 memReq", memReq, 0);
    rstN = 1;
    repeat (200) @(negedge clk);
    check("R2 waits for start", mode, 0);
    check("R2 preload count", preLog.size(), LEN);
    ordered = 1;
    foreach (preLog[i]) if (preLog[i] != 8'(i)) ordered = 0;
    check("R2 preload order", ordered, 1);
    start = 1; recordPre = 0;
    @(negedge clk);
    check("R2 enter active", mode, 1);

    fetch(8'h03, 1, "R3 active hit");
    fetch(8'h25, 0, "R4 active miss");
    repeat (2) @(negedge clk);
    check("R5 equal counts stay active", mode, 1);
    fetch(8'h25, 0, "R4 miss not filled");
    repeat (2) @(negedge clk);
    check("R5 enter shadow", mode, 2);
    check("R5 throttle", throttle, 1);

    fetch(8'h47, 0, "R6 shadow miss");
    fetch(8'h47, 1, "R6 filled line hits");
    fetch(8'h03, 1, "R3 shadow hit");
    fetch(8'h07, 0, "R6 replaced line misses");
    for (int i = 0; i < 6; i++) fetch(8'h07, 1, "R6 refill hit");
    check("R8 stays shadow", mode, 2);
    check("R8 throttle held", throttle, 1);

    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
    check("R8 end mode", mode, 3);
    check("R8 throttle low in end", throttle, 0);
    fetchValid = 1; fetchAddr = 8'h03; r0 = reqCount; sawReady = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); #1; if (fetchReady) sawReady = 1; end
    fetchValid = 0;
    check("R8 no answer in end", sawReady, 0);
    check("R8 no request in end", reqCount - r0, 0);
    check("R8 end holds", mode, 3);

    // second run: saturation and done from active
    @(negedge clk); rstN = 0; start = 1;
    repeat (2) @(negedge clk); rstN = 1;
    guard = 0;
    while (mode != 2'd1 && guard < 500) begin @(negedge clk); guard++; end
    check("R2 start held reaches active", mode, 1);
    fetch(8'h0F, 1, "R3 hit after preload");
    for (int i = 0; i < 9; i++) fetch(8'h0A, 1, "R7 hits");
    for (int i = 0; i < 8; i++) fetch(8'h3A, 0, "R7 misses");
    repeat (2) @(negedge clk);
    check("R7 saturated counters keep active", mode, 1);
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
    check("R10 done from active", mode, 3);
    check("R10 queue drained", expQ.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule